// File: doc/BRIEF.md
# Fetch PC and Flush Controller

This block is the front end of a five-stage in-order integer pipeline. It owns the program counter and walks it through 4-byte instruction words, starting at byte address 4000. It presents the current address, and the matching instruction-store index, to an external instruction store. The word that comes back is captured in a fetch latch, together with its PC, for the decode/register-read stage.

When the execute stage reports a taken conditional branch, the block reloads the PC with the branch target. In the same cycle it raises flush strobes, so that the younger instructions in Fetch and in decode/register-read are turned into invalid no-ops.

When a HALT sits in decode, fetching stops for good and the younger fetched word is discarded. Older instructions are left to drain. Completion is signalled once the HALT reaches write-back. A synchronous initialize input returns the block to its starting state, as reset does.

Top module: `fetch_ctl`

## Requirements
- R1: While rst_n is low, fetch_pc is 4000, fl_valid is 0, fl_instr equals the no-op word (all zeros), fetch_stopped is 0 and done is 0.
- R2: With no initialize, no taken branch, no HALT in decode, no stall and fetch not stopped, the next edge loads fl_instr with imem_word, loads fl_pc with the old fetch_pc, sets fl_valid, and advances fetch_pc by 4.
- R3: fetch_idx always equals (fetch_pc - 4000) / 4, truncated to the index width.
- R4: In any cycle where ex_taken is high, flush_fetch and flush_dr are high. At the next edge, fetch_pc becomes ex_target with its two low bits forced to 0, fl_valid becomes 0 and fl_instr becomes the no-op word.
- R5: A taken branch wins over a decode stall and over a HALT in decode. The redirect happens anyway, and the HALT does not set fetch_stopped.
- R6: With a decode stall and no taken branch, HALT, stop or initialize, fetch_pc, fl_valid, fl_instr and fl_pc hold their values.
- R7: dr_halt without ex_taken clears fl_valid (fl_instr becomes the no-op word) and sets fetch_stopped at the next edge. While fetch_stopped is high and no branch is taken, fetch_pc does not change and fl_valid stays 0.
- R8: done is high in every cycle in which wb_halt is high, and it stays high afterwards until reset or initialize.
- R9: init high at an edge restores the R1 state, regardless of every other input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init | input | 1 | Synchronous initialize |
| fetch_pc | output | AW | Byte address being fetched |
| fetch_idx | output | IDX_W | Instruction-store entry index of fetch_pc |
| imem_word | input | IW | Instruction word at fetch_idx |
| dr_stall | input | 1 | Decode/register-read stage stalled |
| dr_halt | input | 1 | Valid HALT in decode/register-read |
| ex_taken | input | 1 | Execute stage resolved a taken branch |
| ex_target | input | AW | Branch target byte address |
| wb_halt | input | 1 | HALT is in write-back |
| fl_valid | output | 1 | Fetch latch holds a live instruction |
| fl_instr | output | IW | Fetch latch instruction word |
| fl_pc | output | AW | Fetch latch instruction address |
| flush_fetch | output | 1 | Squash the Fetch slot |
| flush_dr | output | 1 | Squash the decode/register-read slot |
| fetch_stopped | output | 1 | Fetching halted by a decoded HALT |
| done | output | 1 | HALT has reached write-back |

## Verification
A taken branch can coincide with a decode stall and with a HALT in decode, and both pairings decide which next state wins. The bench forces each pairing directly, then lets the random stream raise ex_taken, dr_stall and dr_halt together at independent rates.

Each outcome is judged against a bench model. That model expects the redirect to the word-aligned target, an invalid no-op latch, and fetch_stopped left clear. It also confirms at the fetch address and latch ports that the stall hold did not take effect.

// File: rtl/fetch_ctl.sv
module fetch_ctl #(
  parameter int          AW       = 32,
  parameter int          IW       = 32,
  parameter int          IDX_W    = 10,
  parameter int unsigned BASE     = 4000,
  parameter logic [IW-1:0] NOP_WORD = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init,
  output logic [AW-1:0]    fetch_pc,
  output logic [IDX_W-1:0] fetch_idx,
  input  logic [IW-1:0]    imem_word,
  input  logic             dr_stall,
  input  logic             dr_halt,
  input  logic             ex_taken,
  input  logic [AW-1:0]    ex_target,
  input  logic             wb_halt,
  output logic             fl_valid,
  output logic [IW-1:0]    fl_instr,
  output logic [AW-1:0]    fl_pc,
  output logic             flush_fetch,
  output logic             flush_dr,
  output logic             fetch_stopped,
  output logic             done
);
  localparam logic [AW-1:0] BASE_PC = AW'(BASE);

  logic [AW-1:0] pc_q;
  logic          lock_q, done_q;

  wire [AW-1:0] tgt      = ex_target & ~AW'(3);
  wire [AW-1:0] off      = pc_q - BASE_PC;
  wire          halt_now = dr_halt & ~ex_taken;
  wire          stop     = lock_q | halt_now;

  assign fetch_pc      = pc_q;
  assign fetch_idx     = IDX_W'(off >> 2);
  assign flush_fetch   = ex_taken;
  assign flush_dr      = ex_taken;
  assign fetch_stopped = lock_q;
  assign done          = done_q | wb_halt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q     <= BASE_PC;
      fl_valid <= 1'b0;
      fl_instr <= NOP_WORD;
      fl_pc    <= BASE_PC;
      lock_q   <= 1'b0;
      done_q   <= 1'b0;
    end else if (init) begin
      pc_q     <= BASE_PC;
      fl_valid <= 1'b0;
      fl_instr <= NOP_WORD;
      fl_pc    <= BASE_PC;
      lock_q   <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= done_q | wb_halt;
      if (ex_taken) begin
        pc_q     <= tgt;
        fl_valid <= 1'b0;
        fl_instr <= NOP_WORD;
      end else if (stop) begin
        lock_q   <= 1'b1;
        fl_valid <= 1'b0;
        fl_instr <= NOP_WORD;
      end else if (!dr_stall) begin
        fl_instr <= imem_word;
        fl_pc    <= pc_q;
        fl_valid <= 1'b1;
        pc_q     <= pc_q + AW'(4);
      end
    end
  end

  // R2
  seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!init && !ex_taken && !dr_halt && !lock_q && !dr_stall)
      |=> (fetch_pc == $past(fetch_pc) + AW'(4)) && fl_valid && (fl_pc == $past(fetch_pc)));

  // R4
  redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_taken && !init) |=> (fetch_pc == ($past(ex_target) & ~AW'(3))) && !fl_valid);

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dr_stall && !init && !ex_taken && !dr_halt && !lock_q)
      |=> $stable(fetch_pc) && $stable(fl_instr) && $stable(fl_valid));

  // R7
  halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_stopped && !init && !ex_taken) |=> $stable(fetch_pc) && !fl_valid && fetch_stopped);

  // R8
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !init) |=> done);

  // R9
  init_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init |=> (fetch_pc == BASE_PC) && !fl_valid && !fetch_stopped);
endmodule

// File: tb/test_fetch_ctl.sv
module test_fetch_ctl;
  localparam int AW = 32, IW = 32, IDX_W = 10;
  localparam logic [AW-1:0] BASE = 32'd4000;
  localparam logic [IW-1:0] NOP = '0;

  logic clk = 1'b0, rst_n = 1'b0, init = 1'b0;
  logic dr_stall = 1'b0, dr_halt = 1'b0, ex_taken = 1'b0, wb_halt = 1'b0;
  logic [AW-1:0] ex_target = '0;
  logic [AW-1:0] fetch_pc, fl_pc;
  logic [IDX_W-1:0] fetch_idx;
  logic [IW-1:0] imem_word, fl_instr;
  logic fl_valid, flush_fetch, flush_dr, fetch_stopped, done;

  int checks = 0, fails = 0;
  logic [AW-1:0] m_pc, m_fpc;
  logic [IW-1:0] m_ins;
  logic m_v, m_lock, m_done;

  always #4 clk = ~clk;

  function automatic logic [IW-1:0] word_of(input logic [IDX_W-1:0] k);
    return 32'(k) * 32'h9E3779B1 + 32'h01234567;
  endfunction

  function automatic logic [IDX_W-1:0] idx_of(input logic [AW-1:0] pc);
    return IDX_W'((pc - BASE) / 4);
  endfunction

  assign imem_word = word_of(fetch_idx);

  fetch_ctl i_fetch_ctl (
    .clk(clk), .rst_n(rst_n), .init(init), .fetch_pc(fetch_pc), .fetch_idx(fetch_idx),
    .imem_word(imem_word), .dr_stall(dr_stall), .dr_halt(dr_halt), .ex_taken(ex_taken),
    .ex_target(ex_target), .wb_halt(wb_halt), .fl_valid(fl_valid), .fl_instr(fl_instr),
    .fl_pc(fl_pc), .flush_fetch(flush_fetch), .flush_dr(flush_dr),
    .fetch_stopped(fetch_stopped), .done(done));

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_pc = BASE; m_fpc = BASE; m_ins = NOP; m_v = 1'b0; m_lock = 1'b0; m_done = 1'b0;
  endtask

  task automatic step(input bit i, input bit st, input bit h, input bit tk,
                      input logic [AW-1:0] tg, input bit wh);
    string tag;
    init = i; dr_stall = st; dr_halt = h; ex_taken = tk; ex_target = tg; wb_halt = wh;
    #1;
    chk(flush_fetch == tk && flush_dr == tk, "R4 flush", {flush_fetch, flush_dr}, {tk, tk});
    chk(done == (m_done | wh), "R8 done", done, m_done | wh);
    chk(fetch_pc == m_pc, "R2 fetch_pc", fetch_pc, m_pc);
    chk(fetch_idx == idx_of(m_pc), "R3 fetch_idx", fetch_idx, idx_of(m_pc));
    if (i) begin
      model_reset(); tag = "R9";
    end else begin
      m_done = m_done | wh;
      if (tk) begin
        m_pc = tg & ~32'd3; m_v = 1'b0; m_ins = NOP; tag = (st || h) ? "R5" : "R4";
      end else if (m_lock || h) begin
        m_lock = 1'b1; m_v = 1'b0; m_ins = NOP; tag = "R7";
      end else if (st) begin
        tag = "R6";
      end else begin
        m_ins = word_of(idx_of(m_pc)); m_fpc = m_pc; m_v = 1'b1; m_pc = m_pc + 4; tag = "R2";
      end
    end
    @(posedge clk); @(negedge clk);
    chk(fetch_pc == m_pc, {tag, " pc"}, fetch_pc, m_pc);
    chk(fl_valid == m_v, {tag, " valid"}, fl_valid, m_v);
    chk(fl_instr == m_ins, {tag, " instr"}, fl_instr, m_ins);
    chk(fl_pc == m_fpc, {tag, " fl_pc"}, fl_pc, m_fpc);
    chk(fetch_stopped == m_lock, {tag, " stopped"}, fetch_stopped, m_lock);
  endtask

  initial begin
    #(200000 * 8);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    @(negedge clk); @(negedge clk);
    // R1 reset state
    chk(fetch_pc == BASE, "R1 pc", fetch_pc, BASE);
    chk(!fl_valid && fl_instr == NOP, "R1 latch", {fl_valid, fl_instr}, {1'b0, NOP});
    chk(!done && !fetch_stopped, "R1 flags", {done, fetch_stopped}, 2'b00);
    rst_n = 1'b1;
    for (int k = 0; k < 5; k++) step(0, 0, 0, 0, '0, 0);       // R2
    step(0, 1, 0, 0, '0, 0); step(0, 1, 0, 0, '0, 0);          // R6
    step(0, 1, 0, 1, 32'd4102, 0);                             // R5 stall+taken
    step(0, 0, 0, 0, '0, 0);
    step(0, 0, 1, 1, 32'd4008, 0);                             // R5 halt+taken
    step(0, 0, 0, 0, '0, 0); step(0, 0, 0, 0, '0, 0);
    step(0, 0, 1, 0, '0, 0);                                   // R7
    step(0, 0, 0, 0, '0, 0); step(0, 0, 0, 0, '0, 0);
    step(0, 0, 0, 0, '0, 1);                                   // R8
    step(0, 0, 0, 0, '0, 0); step(0, 0, 0, 0, '0, 0);
    step(1, 1, 1, 1, 32'd5000, 1);                             // R9
    step(0, 0, 0, 0, '0, 0);
    for (int n = 0; n < 4000; n++) begin
      logic [AW-1:0] t;
      t = BASE + 32'(4 * ($urandom % 300)) + 32'($urandom % 4);
      step(($urandom % 60) == 0, ($urandom % 4) == 0, ($urandom % 30) == 0,
           ($urandom % 7) == 0, t, ($urandom % 40) == 0);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule